// File: doc/BRIEF.md
# Address Translation Pre-Check Stage

This stage runs on every memory request before, or alongside, the translation cache lookup. It resolves the cases that need no cached translation: a clear-exclusive operation, an alignment violation, and an access made while address translation is switched off. It also decides what happens when the lookup misses. A miss on a speculative prefetch becomes an abort and is not serviced. Any other miss starts a page-table walk.

A request is taken in the cycle `req_valid` is high. The block samples the request word, the control bits and the memory-type remap fields on that clock edge. The outcome appears one cycle later as either a response or a walk strobe. The outcome is held in a small state register with four states:

- `ST_IDLE`: nothing is due.
- `ST_DONE`: a fault-free response.
- `ST_FAULT`: an abort, with its code.
- `ST_WALK`: a one-cycle walk request.

Every state is entered from any state through one of the transitions below, chosen on each clock edge:

- `T_NONE` (no request) goes to `ST_IDLE`.
- `T_CLREX`, `T_FLAT` and `T_HIT` go to `ST_DONE`.
- `T_MISALIGN` and `T_PF_MISS` go to `ST_FAULT`.
- `T_MISS` goes to `ST_WALK`.

A new request may be presented on every cycle.

Top module: `xlat_precheck`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `rsp_valid` and `walk_req` are 0.
- R2: A request with `req_clrex`=1 gives, one cycle later, a response with `rsp_paddr`=0, `rsp_uncached`=1, `rsp_final`=1 and `rsp_fault`=0. This holds whatever the alignment, translation-enable or miss inputs are.
- R3: On a fault-free response, `rsp_uncached` is 1 in two cases. The first is a fetch (`req_kind`=2) with `ctl_icache_en`=0. The second is a read (0) or write (1) with `ctl_dcache_en`=0.
- R4: A read or write raises a fault with code 1 (alignment) and `rsp_fault_pf`=0 under two conditions. At least one of `ctl_align_strict`=1 or `req_allow_unal`=0 must hold, and `req_vaddr[ALIGN_W-1:0] & req_align_mask` must be non-zero. Fetches never raise this fault.
- R5: When `ctl_align_strict`=0 and `req_allow_unal`=1, no alignment fault is raised for any address.
- R6: With `ctl_xlat_en`=0 and no alignment fault, the response has `rsp_paddr`=`req_vaddr`, `rsp_final`=1 and no fault. In this case `tlb_miss` has no effect.
- R7: With `ctl_xlat_en`=0 and `ctl_remap_en`=0, `rsp_uncached`=1.
- R8: With `ctl_xlat_en`=0 and `ctl_remap_en`=1, the access is uncacheable if any of three conditions holds: `remap_inner0`=0, `remap_outer0`=0, or `remap_type0`≠2. Otherwise only R3 decides.
- R9: A miss on a request with `req_prefetch`=1 gives a fault with code 2 (translation miss) and `rsp_fault_pf`=1. No walk is requested.
- R10: A miss on any other request raises `walk_req` for exactly one cycle. It carries `walk_vaddr`=`req_vaddr` and `walk_ctx`=`req_ctx`, and `rsp_valid` stays 0 in that cycle.
- R11: A hit with translation on gives `rsp_valid`=1, `rsp_final`=0, `rsp_paddr`=0 and no fault.
- R12: Outcomes are due exactly one cycle after the request. A cycle without a request yields no response and no walk. Priority runs clear-exclusive, then alignment, then translation off, then the miss decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | ADDR_W | Virtual address |
| req_ctx | input | CTX_W | Context identifier |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_clrex | input | 1 | Clear-exclusive operation |
| req_prefetch | input | 1 | Speculative prefetch |
| req_allow_unal | input | 1 | Request tolerates misalignment |
| req_align_mask | input | ALIGN_W | Address bits that must be zero |
| tlb_miss | input | 1 | Translation lookup missed |
| ctl_xlat_en | input | 1 | Address translation enabled |
| ctl_align_strict | input | 1 | Strict alignment checking |
| ctl_icache_en | input | 1 | Instruction cache enabled |
| ctl_dcache_en | input | 1 | Data cache enabled |
| ctl_remap_en | input | 1 | Memory-type remap enabled |
| remap_type0 | input | 2 | Primary memory type, region 0 |
| remap_inner0 | input | 2 | Inner normal-memory attribute, region 0 |
| remap_outer0 | input | 2 | Outer normal-memory attribute, region 0 |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | ADDR_W | Physical address when final |
| rsp_uncached | output | 1 | Access must bypass caches |
| rsp_final | output | 1 | Address resolved without the cache of translations |
| rsp_fault | output | 1 | Abort raised |
| rsp_fault_code | output | 2 | 0 none, 1 alignment, 2 translation miss |
| rsp_fault_pf | output | 1 | 1 prefetch abort, 0 data abort |
| walk_req | output | 1 | Start a page-table walk |
| walk_vaddr | output | ADDR_W | Address to walk |
| walk_ctx | output | CTX_W | Context to walk |

## Verification
Every outcome is registered, whether response, fault or walk strobe. It is due in the single cycle after the clock edge that samples the request, and it is gone again one cycle later unless a new request follows. The bench drives a request on a falling edge. On the next falling edge it compares all outputs against the behavioural expectation for that request, so each vector is checked exactly one register stage later. Idle cycles between requests are compared the same way, which catches a response or strobe that lingers for a second cycle.

// File: rtl/pck_pkg.sv
package pck_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        FC_NONE     = 2'd0,
        FC_ALIGN    = 2'd1,
        FC_TLB_MISS = 2'd2
    } fault_code_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2,
        ST_WALK  = 2'd3
    } stage_e;

    // Memory-type value that marks region 0 as normal memory
    localparam logic [1:0] TYPE_NORMAL = 2'd2;

endpackage

// File: rtl/pck_align.sv
module pck_align
    import pck_pkg::*;
#(
    parameter int ALIGN_W = 4
) (
    input  logic [1:0]         kind,
    input  logic [ALIGN_W-1:0] addr_low,
    input  logic [ALIGN_W-1:0] mask,
    input  logic               strict,
    input  logic               allow_unal,
    output logic               misaligned
);
    logic enforce;
    logic overlap;

    always_comb begin
        enforce    = strict || !allow_unal;
        overlap    = |(addr_low & mask);
        misaligned = (kind != KIND_FETCH) && enforce && overlap;
    end
endmodule

// File: rtl/pck_cache.sv
module pck_cache
    import pck_pkg::*;
(
    input  logic       is_fetch,
    input  logic       icache_en,
    input  logic       dcache_en,
    input  logic       remap_en,
    input  logic [1:0] type0,
    input  logic [1:0] inner0,
    input  logic [1:0] outer0,
    output logic       unc_enable,
    output logic       unc_flat
);
    logic remap_unc;

    always_comb begin
        unc_enable = is_fetch ? !icache_en : !dcache_en;
        remap_unc  = (inner0 == 2'd0) || (outer0 == 2'd0) || (type0 != TYPE_NORMAL);
        unc_flat   = remap_en ? remap_unc : 1'b1;
    end
endmodule

// File: rtl/pck_decide.sv
module pck_decide
    import pck_pkg::*;
(
    input  logic        valid,
    input  logic        clrex,
    input  logic        misaligned,
    input  logic        xlat_en,
    input  logic        tlb_miss,
    input  logic        prefetch,
    output stage_e      nxt_state,
    output fault_code_e nxt_code,
    output logic        nxt_pf,
    output logic        nxt_final
);
    always_comb begin
        nxt_state = ST_IDLE;
        nxt_code  = FC_NONE;
        nxt_pf    = 1'b0;
        nxt_final = 1'b0;
        if (valid) begin
            if (clrex) begin                    // T_CLREX
                nxt_state = ST_DONE;
                nxt_final = 1'b1;
            end else if (misaligned) begin      // T_MISALIGN
                nxt_state = ST_FAULT;
                nxt_code  = FC_ALIGN;
            end else if (!xlat_en) begin        // T_FLAT
                nxt_state = ST_DONE;
                nxt_final = 1'b1;
            end else if (tlb_miss) begin
                if (prefetch) begin             // T_PF_MISS
                    nxt_state = ST_FAULT;
                    nxt_code  = FC_TLB_MISS;
                    nxt_pf    = 1'b1;
                end else begin                  // T_MISS
                    nxt_state = ST_WALK;
                end
            end else begin                      // T_HIT
                nxt_state = ST_DONE;
            end
        end
    end
endmodule

// File: rtl/xlat_precheck.sv
module xlat_precheck
    import pck_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CTX_W   = 8,
    parameter int ALIGN_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_vaddr,
    input  logic [CTX_W-1:0]   req_ctx,
    input  logic [1:0]         req_kind,
    input  logic               req_clrex,
    input  logic               req_prefetch,
    input  logic               req_allow_unal,
    input  logic [ALIGN_W-1:0] req_align_mask,
    input  logic               tlb_miss,
    input  logic               ctl_xlat_en,
    input  logic               ctl_align_strict,
    input  logic               ctl_icache_en,
    input  logic               ctl_dcache_en,
    input  logic               ctl_remap_en,
    input  logic [1:0]         remap_type0,
    input  logic [1:0]         remap_inner0,
    input  logic [1:0]         remap_outer0,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_paddr,
    output logic               rsp_uncached,
    output logic               rsp_final,
    output logic               rsp_fault,
    output logic [1:0]         rsp_fault_code,
    output logic               rsp_fault_pf,
    output logic               walk_req,
    output logic [ADDR_W-1:0]  walk_vaddr,
    output logic [CTX_W-1:0]   walk_ctx
);
    localparam logic [ADDR_W-1:0] ZERO_ADDR = '0;

    logic        misaligned;
    logic        unc_enable;
    logic        unc_flat;
    logic        is_fetch;
    stage_e      state_q, state_d;
    fault_code_e code_d, code_q;
    logic        pf_d, pf_q;
    logic        final_d, final_q;
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic        unc_d, unc_q;
    logic [CTX_W-1:0]  ctx_q;

    assign is_fetch = (req_kind == KIND_FETCH);

    pck_align #(.ALIGN_W(ALIGN_W)) i_align (
        .kind       (req_kind),
        .addr_low   (req_vaddr[ALIGN_W-1:0]),
        .mask       (req_align_mask),
        .strict     (ctl_align_strict),
        .allow_unal (req_allow_unal),
        .misaligned (misaligned)
    );

    pck_cache i_cache (
        .is_fetch   (is_fetch),
        .icache_en  (ctl_icache_en),
        .dcache_en  (ctl_dcache_en),
        .remap_en   (ctl_remap_en),
        .type0      (remap_type0),
        .inner0     (remap_inner0),
        .outer0     (remap_outer0),
        .unc_enable (unc_enable),
        .unc_flat   (unc_flat)
    );

    pck_decide i_decide (
        .valid      (req_valid),
        .clrex      (req_clrex),
        .misaligned (misaligned),
        .xlat_en    (ctl_xlat_en),
        .tlb_miss   (tlb_miss),
        .prefetch   (req_prefetch),
        .nxt_state  (state_d),
        .nxt_code   (code_d),
        .nxt_pf     (pf_d),
        .nxt_final  (final_d)
    );

    // Payload chosen for the outcome being registered
    always_comb begin
        if (req_clrex) begin
            addr_d = ZERO_ADDR;
            unc_d  = 1'b1;
        end else if (!ctl_xlat_en) begin
            addr_d = req_vaddr;
            unc_d  = unc_enable || unc_flat;
        end else begin
            addr_d = ZERO_ADDR;
            unc_d  = unc_enable;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Payload register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            ctx_q   <= '0;
            unc_q   <= 1'b0;
            code_q  <= FC_NONE;
            pf_q    <= 1'b0;
            final_q <= 1'b0;
        end else begin
            addr_q  <= addr_d;
            ctx_q   <= req_ctx;
            unc_q   <= unc_d;
            code_q  <= code_d;
            pf_q    <= pf_d;
            final_q <= final_d;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        rsp_valid      = 1'b0;
        rsp_paddr      = '0;
        rsp_uncached   = 1'b0;
        rsp_final      = 1'b0;
        rsp_fault      = 1'b0;
        rsp_fault_code = FC_NONE;
        rsp_fault_pf   = 1'b0;
        walk_req       = 1'b0;
        walk_vaddr     = '0;
        walk_ctx       = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DONE: begin
                rsp_valid    = 1'b1;
                rsp_paddr    = addr_q;
                rsp_uncached = unc_q;
                rsp_final    = final_q;
            end
            ST_FAULT: begin
                rsp_valid      = 1'b1;
                rsp_fault      = 1'b1;
                rsp_fault_code = code_q;
                rsp_fault_pf   = pf_q;
            end
            ST_WALK: begin
                walk_req   = 1'b1;
                walk_vaddr = addr_walk();
                walk_ctx   = ctx_q;
            end
            default: ;
        endcase
    end

    // Walk address: the registered virtual address captured for walks
    logic [ADDR_W-1:0] walk_addr_q;
    always_ff @(posedge clk) begin
        if (!rst_n) walk_addr_q <= '0;
        else        walk_addr_q <= req_vaddr;
    end

    function automatic logic [ADDR_W-1:0] addr_walk();
        return walk_addr_q;
    endfunction

    // ---------------- assertions ----------------
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !$past(rst_n) |-> (!rsp_valid && !walk_req));

    a_r12_idle_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (!rsp_valid && !walk_req));

    a_r10_walk_excludes_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !rsp_valid);

    a_r10_walk_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !req_valid) |=> !walk_req);

    a_r2_clrex_result: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid) && $past(req_clrex)) |->
        (rsp_valid && !rsp_fault && rsp_uncached && rsp_final && rsp_paddr == '0));

    a_r4_fetch_never_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid) && $past(req_kind) == KIND_FETCH) |->
        !(rsp_fault && rsp_fault_code == FC_ALIGN));

    a_r9_prefetch_miss_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid) && $past(req_prefetch) && $past(tlb_miss)) |-> !walk_req);

    a_r6_flat_address: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_final && !$past(req_clrex)) |-> (rsp_paddr == $past(req_vaddr)));
endmodule

// File: tb/test_xlat_precheck.sv
module test_xlat_precheck;
    localparam int AW = 32;
    localparam int CW = 8;
    localparam int LW = 4;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] vaddr;
        logic [CW-1:0] ctx;
        logic [1:0]    kind;
        logic          clrex;
        logic          prefetch;
        logic          allow;
        logic [LW-1:0] mask;
        logic          miss;
        logic          xlat;
        logic          strict;
        logic          ic;
        logic          dc;
        logic          remap;
        logic [1:0]    typ;
        logic [1:0]    inner;
        logic [1:0]    outer;
    } stim_t;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] paddr;
        logic          unc;
        logic          fin;
        logic          fault;
        logic [1:0]    code;
        logic          pf;
        logic          walk;
        logic [AW-1:0] wva;
        logic [CW-1:0] wctx;
    } exp_t;

    logic clk = 0;
    logic rst_n = 0;
    stim_t s_in;
    exp_t  act;
    logic [AW-1:0] rsp_paddr, walk_vaddr;
    logic [CW-1:0] walk_ctx;
    logic rsp_valid, rsp_uncached, rsp_final, rsp_fault, rsp_fault_pf, walk_req;
    logic [1:0] rsp_fault_code;

    int checks = 0;
    int fails  = 0;
    exp_t  pend_exp;
    string pend_tag;

    always #5 clk = ~clk;

    xlat_precheck #(.ADDR_W(AW), .CTX_W(CW), .ALIGN_W(LW)) i_xlat_precheck (
        .clk(clk), .rst_n(rst_n),
        .req_valid(s_in.valid), .req_vaddr(s_in.vaddr), .req_ctx(s_in.ctx),
        .req_kind(s_in.kind), .req_clrex(s_in.clrex), .req_prefetch(s_in.prefetch),
        .req_allow_unal(s_in.allow), .req_align_mask(s_in.mask), .tlb_miss(s_in.miss),
        .ctl_xlat_en(s_in.xlat), .ctl_align_strict(s_in.strict),
        .ctl_icache_en(s_in.ic), .ctl_dcache_en(s_in.dc), .ctl_remap_en(s_in.remap),
        .remap_type0(s_in.typ), .remap_inner0(s_in.inner), .remap_outer0(s_in.outer),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_uncached(rsp_uncached),
        .rsp_final(rsp_final), .rsp_fault(rsp_fault), .rsp_fault_code(rsp_fault_code),
        .rsp_fault_pf(rsp_fault_pf), .walk_req(walk_req), .walk_vaddr(walk_vaddr),
        .walk_ctx(walk_ctx)
    );

    assign act = '{valid: rsp_valid, paddr: rsp_paddr, unc: rsp_uncached, fin: rsp_final,
                   fault: rsp_fault, code: rsp_fault_code, pf: rsp_fault_pf,
                   walk: walk_req, wva: walk_vaddr, wctx: walk_ctx};

    // Behavioural expectation straight from the requirements
    function automatic exp_t model(input stim_t s, output string tag);
        exp_t e = '0;
        bit fetch = (s.kind == 2'd2);
        bit overlap = ((s.vaddr[LW-1:0] & s.mask) != 0);
        bit cache_off = fetch ? !s.ic : !s.dc;
        tag = "R12";
        if (!s.valid) return e;
        if (s.clrex) begin
            tag = "R2";
            e.valid = 1; e.unc = 1; e.fin = 1;
        end else if (!fetch && overlap && (s.strict || !s.allow)) begin
            tag = "R4";
            e.valid = 1; e.fault = 1; e.code = 2'd1;
        end else if (!s.xlat) begin
            tag = s.remap ? "R6 R8" : "R6 R7";
            if (!fetch && overlap) tag = {tag, " R5"};
            e.valid = 1; e.fin = 1; e.paddr = s.vaddr;
            if (!s.remap) e.unc = 1;
            else e.unc = cache_off || s.inner == 0 || s.outer == 0 || s.typ != 2'd2;
            e.unc = e.unc || cache_off;
        end else if (s.miss && s.prefetch) begin
            tag = "R9";
            e.valid = 1; e.fault = 1; e.code = 2'd2; e.pf = 1;
        end else if (s.miss) begin
            tag = "R10";
            e.walk = 1; e.wva = s.vaddr; e.wctx = s.ctx;
        end else begin
            tag = (!fetch && overlap) ? "R11 R3 R5" : "R11 R3";
            e.valid = 1; e.unc = cache_off;
        end
        return e;
    endfunction

    task automatic compare(input exp_t e, input string tag);
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, e);
        end
    endtask

    task automatic apply(input stim_t s);
        @(negedge clk);
        compare(pend_exp, pend_tag);
        s_in = s;
        pend_exp = model(s, pend_tag);
    endtask

    function automatic stim_t base();
        stim_t s = '0;
        s.valid = 1; s.kind = 2'd0; s.allow = 1; s.xlat = 1;
        s.ic = 1; s.dc = 1; s.typ = 2'd2; s.inner = 2'd1; s.outer = 2'd1;
        s.vaddr = 32'h1234_5670; s.ctx = 8'h3c;
        return s;
    endfunction

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        stim_t s;
        s_in = '0;
        repeat (3) @(negedge clk);
        compare('0, "R1");
        rst_n = 1;
        pend_exp = '0; pend_tag = "R1";

        // R11 R3 plain hit, caches on
        s = base(); apply(s);
        s.kind = 2'd2; s.ic = 0; apply(s);            // R3 fetch uncached
        s = base(); s.dc = 0; apply(s);               // R3 data uncached
        // R2 clear-exclusive beats misalignment and flat mode
        s = base(); s.clrex = 1; s.vaddr = 32'hffff_ffff; s.mask = 4'hf;
        s.allow = 0; s.xlat = 0; apply(s);
        // R4 misaligned write, strict on
        s = base(); s.kind = 2'd1; s.vaddr = 32'h1002; s.mask = 4'h3; s.strict = 1; apply(s);
        s.strict = 0; s.allow = 0; apply(s);          // R4 via request flag
        s.allow = 1; apply(s);                        // R5 waived
        s.kind = 2'd2; s.strict = 1; apply(s);        // R4 fetch exempt
        // R6 R7 flat, miss ignored
        s = base(); s.xlat = 0; s.miss = 1; s.vaddr = 32'hdead_beef; apply(s);
        s.remap = 1; apply(s);                        // R8 normal -> cacheable
        s.typ = 2'd1; apply(s);                       // R8 type
        s.typ = 2'd2; s.inner = 0; apply(s);          // R8 inner
        s.inner = 2'd3; s.outer = 0; apply(s);        // R8 outer
        // R9 prefetch miss, R10 walk
        s = base(); s.miss = 1; s.prefetch = 1; apply(s);
        s.prefetch = 0; s.ctx = 8'ha5; apply(s);      // R10
        s.valid = 0; apply(s);                        // R10 one cycle only, R12
        s = base(); s.miss = 1; s.vaddr = 32'h0000_4000; apply(s);
        apply(s);                                     // back-to-back walks

        for (int i = 0; i < 3000; i++) begin
            s = '0;
            s.valid    = ($urandom_range(0, 7) != 0);
            s.vaddr    = $urandom;
            s.ctx      = 8'($urandom);
            s.kind     = 2'($urandom_range(0, 2));
            s.clrex    = ($urandom_range(0, 9) == 0);
            s.prefetch = $urandom_range(0, 1) == 1;
            s.allow    = $urandom_range(0, 1) == 1;
            s.mask     = 4'((1 << $urandom_range(0, 4)) - 1);
            s.miss     = $urandom_range(0, 1) == 1;
            s.xlat     = ($urandom_range(0, 3) != 0);
            s.strict   = $urandom_range(0, 1) == 1;
            s.ic       = $urandom_range(0, 1) == 1;
            s.dc       = $urandom_range(0, 1) == 1;
            s.remap    = $urandom_range(0, 1) == 1;
            s.typ      = 2'($urandom);
            s.inner    = 2'($urandom);
            s.outer    = 2'($urandom);
            apply(s);
        end
        s = '0; apply(s); apply(s);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule